// File: doc/BRIEF.md
# SPI Slave Frame Engine with Parity

This block is the target side of an SPI link. The serial clock, the chip select and the master-out data come in as pins. They are brought into the system clock domain through short synchronizers. From them the block builds frames whose payload length, bit order and optional parity bit are set by static configuration inputs. Transmit words arrive over a valid/ready handshake into a single holding register. Received words leave over a second valid/ready handshake.

The slave launches each outgoing bit on the first edge of a serial clock period and samples the incoming bit on the second edge. A clock-polarity input picks which pin transition counts as the first edge. When no frame is running, the output pin shows a programmable idle level. If a frame starts with no transmit word waiting, the pin shows a programmable underrun level for the whole frame. Parity mismatch, overrun and underrun are reported on sticky flags. A synchronous soft reset input clears these flags.

Top module: `spi_slave_engine`

## Requirements
- R1: A frame holds `cfg_len` payload bits plus one parity bit when `cfg_par_en`=1. The received word (zero above `cfg_len`) appears on `rx_data` with `rx_valid` only after the last second edge, together with exactly one `frame_done` pulse. Legal `cfg_len` is 8..32 without parity and 7..31 with parity.
- R2: With `cfg_msb_first`=1, payload bit `cfg_len`-1 travels first. With `cfg_msb_first`=0, bit 0 travels first. The parity bit always travels last.
- R3: With `cfg_cpol`=0, the rising edge of `sck` launches `miso_o` and the falling edge samples `mosi`. With `cfg_cpol`=1, these roles swap.
- R4: The transmitted parity bit is the XOR of the payload bits, inverted when `cfg_par_odd`=1 (0 = even, 1 = odd).
- R5: A received frame with `cfg_par_en`=1 whose parity does not match sets `err_parity`. The word is still delivered.
- R6: `cfg_mode` 0 is full duplex, 1 is transmit only (nothing is delivered on `rx_data`) and 2 is receive only. In receive-only mode the holding register is not consumed and the pin keeps its idle level.
- R7: With no frame running, `cfg_idle` selects the pin state: 0 drives low, 1 drives high, 2 holds the last driven bit, 3 releases the pin (`miso_oe`=0).
- R8: A frame that starts with the transmit holding register empty sets `err_underrun`. Every bit of that frame is driven at `cfg_urun_lvl`.
- R9: A frame that completes while `rx_valid` is high and `rx_ready` is low sets `err_overrun`. The new word is dropped and `rx_data` keeps the old word.
- R10: Raising `cs_n` inside a frame abandons that frame: no word is delivered, there is no `frame_done`, and the next frame starts again from bit 0.
- R11: `soft_rst` clears all flags, `rx_valid` and the transmit holding register, and returns the block to idle.
- R12: `tx_ready` stays low while the holding register is full. `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all state and flags |
| cfg_len | input | 6 | Payload length in bits |
| cfg_par_en | input | 1 | Append and check a parity bit |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_cpol | input | 1 | Idle level of sck; selects the first edge |
| cfg_mode | input | 2 | 0 duplex, 1 transmit only, 2 receive only |
| cfg_idle | input | 2 | Idle pin state select |
| cfg_urun_lvl | input | 1 | Pin level during an underrun frame |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| mosi | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable of the data-out pin |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Received word taken |
| frame_done | output | 1 | One-cycle pulse at frame completion |
| err_parity | output | 1 | Sticky parity mismatch flag |
| err_overrun | output | 1 | Sticky overrun flag |
| err_underrun | output | 1 | Sticky underrun flag |

## Verification
A pin transition reaches the engine three system clocks later: two synchronizer stages, then the edge register. The driven `miso_o` bit is therefore settled about four clocks after a first edge, and a word or flag is settled about four clocks after the final second edge. The bench holds each sck phase for eight clocks. It reads `miso_o` on the last clock before the second edge, checks `rx_valid` just before the final second edge, and checks results four clocks after the frame ends. Chip select changes get six clocks of settling on each side.

// File: rtl/spi_slave_engine.sv
module spi_slave_engine #(
  parameter int MAXW = 32,
  parameter int SYNC = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        soft_rst,
  input  logic [$clog2(MAXW+1)-1:0]   cfg_len,
  input  logic                        cfg_par_en,
  input  logic                        cfg_par_odd,
  input  logic                        cfg_msb_first,
  input  logic                        cfg_cpol,
  input  logic [1:0]                  cfg_mode,
  input  logic [1:0]                  cfg_idle,
  input  logic                        cfg_urun_lvl,
  input  logic                        sck,
  input  logic                        cs_n,
  input  logic                        mosi,
  output logic                        miso_o,
  output logic                        miso_oe,
  input  logic [MAXW-1:0]             tx_data,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  output logic [MAXW-1:0]             rx_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic                        frame_done,
  output logic                        err_parity,
  output logic                        err_overrun,
  output logic                        err_underrun
);
  localparam int CW = $clog2(MAXW + 1);

  logic [SYNC:0]   sck_p;
  logic [SYNC-1:0] cs_p, mosi_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC-1:0], sck};
      cs_p   <= {cs_p[SYNC-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
    end
  end

  wire cs_act   = !cs_p[SYNC-1];
  wire mosi_s   = mosi_p[SYNC-1];
  wire sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  wire sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  wire first_e  = cs_act & (cfg_cpol ? sck_fall : sck_rise);
  wire second_e = cs_act & (cfg_cpol ? sck_rise : sck_fall);
  wire tx_en    = cfg_mode != 2'd2;
  wire rx_en    = cfg_mode != 2'd1;

  logic          busy, urun, drv, last_bit, txbuf_full;
  logic [CW-1:0] bitk;
  logic [MAXW-1:0] txbuf, tx_word, rx_sh;

  wire [CW-1:0]   nbits = cfg_len + CW'(cfg_par_en);
  wire [MAXW-1:0] mask  = ~({MAXW{1'b1}} << cfg_len);
  wire [CW-1:0]   kn    = busy ? bitk + CW'(1) : '0;
  wire [MAXW-1:0] src   = busy ? tx_word : txbuf;
  wire [CW-1:0]   tpos  = cfg_msb_first ? cfg_len - CW'(1) - kn : kn;
  wire            tbit  = (kn == cfg_len) ? (^(src & mask) ^ cfg_par_odd)
                                          : |(src & (MAXW'(1) << tpos));
  wire            dval  = (busy ? urun : !txbuf_full) ? cfg_urun_lvl : tbit;
  wire [CW-1:0]   rpos  = cfg_msb_first ? cfg_len - CW'(1) - bitk : bitk;
  wire [MAXW-1:0] rx_nxt = (bitk < cfg_len)
                         ? ((rx_sh & ~(MAXW'(1) << rpos)) | (MAXW'(mosi_s) << rpos))
                         : rx_sh;
  wire            perr  = ^rx_sh ^ mosi_s ^ cfg_par_odd;
  wire            lastb = bitk == nbits - CW'(1);

  assign tx_ready = !txbuf_full;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      busy <= 1'b0;  urun <= 1'b0;  drv <= 1'b0;  last_bit <= 1'b0;
      txbuf_full <= 1'b0;  bitk <= '0;
      txbuf <= '0;  tx_word <= '0;  rx_sh <= '0;  rx_data <= '0;
      rx_valid <= 1'b0;  frame_done <= 1'b0;
      err_parity <= 1'b0;  err_overrun <= 1'b0;  err_underrun <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tx_valid && !txbuf_full) begin
        txbuf      <= tx_data;
        txbuf_full <= 1'b1;
      end
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!cs_act) begin
        busy <= 1'b0;
        bitk <= '0;
      end else if (first_e) begin
        busy <= 1'b1;
        bitk <= kn;
        if (!busy) begin
          rx_sh <= '0;
          urun  <= tx_en && !txbuf_full;
          if (tx_en) begin
            if (txbuf_full) begin
              tx_word    <= txbuf;
              txbuf_full <= 1'b0;
            end else begin
              err_underrun <= 1'b1;
            end
          end
        end
        if (tx_en) begin
          drv      <= dval;
          last_bit <= dval;
        end
      end else if (second_e && busy) begin
        rx_sh <= rx_nxt;
        if (lastb) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
          if (rx_en) begin
            if (rx_valid && !rx_ready) begin
              err_overrun <= 1'b1;
            end else begin
              rx_data  <= rx_nxt;
              rx_valid <= 1'b1;
              if (cfg_par_en && perr) err_parity <= 1'b1;
            end
          end
        end
      end
    end
  end

  wire idle_v = (cfg_idle == 2'd1) | ((cfg_idle == 2'd2) & last_bit);
  assign miso_o  = (busy && tx_en) ? drv : idle_v;
  assign miso_oe = (busy && tx_en) || (cfg_idle != 2'd3);
endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic [1:0]    cfg_mode,
  input logic [1:0]    cfg_idle,
  input logic          miso_oe,
  input logic          tx_ready,
  input logic [31:0]   rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          frame_done,
  input logic          err_parity,
  input logic          err_overrun,
  input logic          err_underrun,
  input logic          busy,
  input logic [CW-1:0] bitk,
  input logic [CW-1:0] nbits
);
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !soft_rst |=> rx_valid && $stable(rx_data));
  p_par_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !soft_rst |=> err_parity);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun && !soft_rst |=> err_overrun);
  p_urun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun && !soft_rst |=> err_underrun);
  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !err_parity && !err_overrun && !err_underrun && !rx_valid && tx_ready && !busy);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> cfg_idle == 2'd3);
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bitk < nbits);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_txonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'd1 && !rx_valid |=> !rx_valid);
endmodule

bind spi_slave_engine spi_slave_engine_chk #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_mode(cfg_mode),
  .cfg_idle(cfg_idle), .miso_oe(miso_oe), .tx_ready(tx_ready),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .frame_done(frame_done), .err_parity(err_parity), .err_overrun(err_overrun),
  .err_underrun(err_underrun), .busy(busy), .bitk(bitk), .nbits(nbits)
);

// File: tb/test_spi_slave_engine.sv
module test_spi_slave_engine;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [5:0] cfg_len = 6'd8;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_msb_first = 1, cfg_cpol = 0, cfg_urun_lvl = 0;
  logic [1:0] cfg_mode = 0, cfg_idle = 0;
  logic sck = 0, cs_n = 1, mosi = 0, miso_o, miso_oe, tx_ready, rx_valid, rx_ready = 0;
  logic tx_valid = 0, frame_done, err_parity, err_overrun, err_underrun;
  logic [31:0] tx_data = 0, rx_data;
  int ntest = 0, nfail = 0, ndone = 0;
  logic rxv_pre;
  logic [32:0] got;

  always #2 clk = ~clk;
  always @(posedge clk) if (frame_done) ndone++;

  spi_slave_engine i_spi_slave_engine (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk();
    return 32'(((64'd1) << cfg_len) - 64'd1);
  endfunction
  function automatic int nb();
    return int'(cfg_len) + int'(cfg_par_en);
  endfunction
  function automatic logic fbit(logic [31:0] w, int k);
    if (k == int'(cfg_len)) return ^(w & msk()) ^ cfg_par_odd;
    return w[cfg_msb_first ? int'(cfg_len) - 1 - k : k];
  endfunction
  function automatic logic [32:0] expm(logic [31:0] w);
    logic [32:0] r = '0;
    for (int k = 0; k < nb(); k++) r[k] = fbit(w, k);
    return r;
  endfunction
  function automatic logic [32:0] flat(logic b);
    logic [32:0] r = '0;
    for (int k = 0; k < nb(); k++) r[k] = b;
    return r;
  endfunction

  task automatic push(logic [31:0] w);
    @(negedge clk); tx_data = w; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
  endtask
  task automatic pull();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask
  task automatic cs_on();
    @(negedge clk); cs_n = 0; repeat (6) @(negedge clk);
  endtask
  task automatic cs_off();
    @(negedge clk); cs_n = 1; repeat (6) @(negedge clk);
  endtask
  task automatic srst();
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
  endtask
  task automatic frame(logic [31:0] mw, logic badp, int cut);
    int run = (cut >= 0) ? cut : nb();
    got = '0;
    for (int k = 0; k < run; k++) begin
      @(negedge clk); sck = ~cfg_cpol;
      mosi = fbit(mw, k) ^ (badp && k == int'(cfg_len));
      repeat (H - 1) @(negedge clk);
      got[k] = miso_o;
      rxv_pre = rx_valid;
      @(negedge clk); sck = cfg_cpol;
      repeat (H - 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask
  task automatic xfer(logic [31:0] tw, logic [31:0] mw, logic badp);
    push(tw); cs_on(); frame(mw, badp, -1); cs_off();
  endtask
  task automatic setpol(logic p);
    @(negedge clk); cfg_cpol = p; sck = p; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int d0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 reset state", {tx_ready, rx_valid, err_parity, err_overrun, err_underrun}, 5'b10000);

    for (int i = 0; i < 4; i++) begin
      cfg_idle = 2'(i); repeat (2) @(negedge clk);
      if (i == 3) check("R7 idle release", miso_oe, 0);
      else check("R7 idle level", {miso_oe, miso_o}, {1'b1, (i == 1)});
    end

    cfg_idle = 2'd2; d0 = ndone;
    xfer(32'hA5, 32'h3C, 0);
    check("R2 msb-first out", got, expm(32'hA5));
    check("R1 rx word", rx_data, 32'h3C);
    check("R1 no early rx_valid", rxv_pre, 0);
    check("R1 one done pulse", ndone - d0, 1);
    check("R7 hold last bit 1", miso_o, 1);
    pull();
    xfer(32'h02, 32'h00, 0);
    check("R7 hold last bit 0", miso_o, 0);
    pull();

    cfg_msb_first = 0; cfg_len = 6'd12;
    xfer(32'h9C3, 32'h5A1, 0);
    check("R2 lsb-first out", got, expm(32'h9C3));
    check("R2 lsb-first in", rx_data, 32'h5A1);
    pull();

    cfg_par_en = 1; cfg_len = 6'd7;
    xfer(32'h6B, 32'h13, 0);
    check("R4 even parity out", got, expm(32'h6B));
    check("R5 good parity", err_parity, 0);
    pull();
    xfer(32'h6B, 32'h13, 1);
    check("R5 bad parity flag", err_parity, 1);
    check("R5 word kept", rx_data, 32'h13);
    pull(); srst();
    cfg_par_odd = 1; cfg_msb_first = 1;
    xfer(32'h55, 32'h7F, 0);
    check("R4 odd parity out", got, expm(32'h55));
    check("R5 odd parity ok", {err_parity, rx_data}, {1'b0, 32'h7F});
    pull();
    cfg_par_en = 0; cfg_par_odd = 0; cfg_len = 6'd8;

    setpol(1);
    xfer(32'hC6, 32'h9E, 0);
    check("R3 cpol1 out", got, expm(32'hC6));
    check("R3 cpol1 in", rx_data, 32'h9E);
    pull(); setpol(0);

    cfg_urun_lvl = 1;
    cs_on(); frame(32'h81, 0, -1); cs_off();
    check("R8 underrun level", got, flat(1));
    check("R8 underrun flag", err_underrun, 1);
    check("R8 rx still works", rx_data, 32'h81);
    pull(); srst();

    xfer(32'h11, 32'hAA, 0);
    check("R12 rx held", {rx_valid, rx_data}, {1'b1, 32'hAA});
    xfer(32'h22, 32'h55, 0);
    check("R9 overrun flag", err_overrun, 1);
    check("R9 old word kept", rx_data, 32'hAA);
    pull();
    srst();
    check("R11 soft reset clears", {err_overrun, rx_valid, tx_ready}, 3'b001);

    d0 = ndone;
    push(32'hF0);
    cs_on(); frame(32'hFF, 0, 3); cs_off();
    check("R10 abort no word", {rx_valid, 32'(ndone - d0)}, 33'd0);
    xfer(32'h3A, 32'h5C, 0);
    check("R10 restart out", got, expm(32'h3A));
    check("R10 restart in", rx_data, 32'h5C);
    pull();

    cfg_mode = 2'd2; cfg_idle = 2'd1;
    xfer(32'h4D, 32'h29, 0);
    check("R12 tx_ready low while held", tx_ready, 0);
    check("R6 rx-only keeps word", got, flat(1));
    check("R6 rx-only receives", rx_data, 32'h29);
    pull();
    cfg_mode = 2'd0;
    cs_on(); frame(32'h00, 0, -1); cs_off();
    check("R6 held word sent later", got, expm(32'h4D));
    pull();
    cfg_mode = 2'd1;
    xfer(32'hB7, 32'h01, 0);
    check("R6 tx-only out", got, expm(32'hB7));
    check("R6 tx-only no rx", rx_valid, 0);
    cfg_mode = 2'd0;

    srst();
    for (int n = 0; n < 40; n++) begin
      logic [31:0] tw = $urandom(), mw = $urandom();
      logic pe = 1'($urandom());
      cfg_par_en = pe; cfg_par_odd = 1'($urandom()); cfg_msb_first = 1'($urandom());
      cfg_len = pe ? 6'(7 + $urandom_range(0, 24)) : 6'(8 + $urandom_range(0, 24));
      if (n < 2) cfg_len = pe ? 6'd31 : 6'd32;
      setpol(1'($urandom()));
      xfer(tw, mw, 0);
      check("R1 random out", got, expm(tw));
      check("R1 random in", {rx_valid, rx_data}, {1'b1, mw & msk()});
      check("R5 random no error", {err_parity, err_overrun, err_underrun}, 3'b000);
      pull();
    end

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule